// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shut-Off

This block is a watchdog timer. It counts ticks of a slow oscillator, which arrives as a clock enable on the system clock. If software stops restarting the count, the block raises a one-cycle system reset. Software restarts the count by pulsing `kick`. A small control byte sets the timeout length, turns the timer on, and holds a shut-off guard flag. Software writes the byte over a plain write strobe and reads it back at any time.

Turning the timer on is always allowed. Turning it off is guarded so that a runaway program cannot silence it by accident. Software first makes one write that sets both the guard flag and the enable flag. The guard flag then stays up for four clock cycles and drops by itself. A write that clears the enable flag takes effect only while the guard flag is up. At any other time that write leaves the timer running.

The timeout is 2^(BASE_LOG2 + sel) oscillator ticks, where sel is the 3-bit length field. With the default BASE_LOG2 of 14, this runs from 16,384 to 2,097,152 ticks.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `sys_rst` is low.
- R2: `rd_data` layout: bit 4 is the guard flag, bit 3 is the enable flag, bits 2:0 are the length select. Bits 7:5 always read 0 and writes to them have no effect. Every write loads bits 2:0 from `wr_data[2:0]`.
- R3: A write with `wr_data[3]`=1 sets the enable flag, whatever its previous state.
- R4: A write with both `wr_data[4]` and `wr_data[3]` at 1 sets the guard flag. The flag then reads 1 for exactly the four cycles after that write and is cleared by hardware after them. A new such write during those cycles restarts the four cycles.
- R5: A write with `wr_data[3]`=0 made in any of the four cycles after an arming write clears the enable flag.
- R6: A write with `wr_data[3]`=0 made while the guard flag reads 0 leaves the enable flag at 1. This includes writes with `wr_data[4]`=1 and `wr_data[3]`=0, which do not arm the guard.
- R7: While enabled, `sys_rst` pulses high for one cycle in the cycle after the 2^(BASE_LOG2+sel)-th `osc_tick` counted since the last restart. The count then restarts from zero.
- R8: Cycles with `osc_tick` low do not advance the count.
- R9: `kick` restarts the count from zero. A kick in the same cycle as the final tick suppresses that reset.
- R10: While the timer is disabled, `sys_rst` stays low and the count is held at zero. After re-enabling, a full period elapses before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osc_tick | input | 1 | One-cycle enable marking each watchdog oscillator tick |
| kick | input | 1 | Restart the timeout count |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Current control byte |
| sys_rst | output | 1 | One-cycle system reset request on timeout |

## Verification
The interesting collision is a kick that lands in the same cycle as the tick that would end the period. Expiry must lose, so no reset appears and the count starts over. A directed case drives an unbroken run of ticks with the shortest length select and places the kick exactly on the final tick. It then confirms that `sys_rst` stays low and that the next reset comes one full period later. Random traffic also mixes kicks, ticks, arming writes and shut-off writes, and a bench model predicts every output in every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned GUARD_B = 4;
  localparam int unsigned ENA_B   = 3;

  typedef struct packed {
    logic             guard;
    logic             ena;
    logic [SEL_W-1:0] sel;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int unsigned WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_bits,
  output wdog_ctrl_t ctrl
);
  localparam int unsigned WW = (WINDOW > 2) ? $clog2(WINDOW) : 1;

  wdog_ctrl_t ctrl_q, ctrl_d;
  logic [WW-1:0] win_q, win_d;
  logic arm;

  assign arm = wr_en & wr_bits[GUARD_B] & wr_bits[ENA_B];

  always_comb begin
    ctrl_d = ctrl_q;
    win_d  = win_q;
    if (arm) begin
      ctrl_d.guard = 1'b1;
      win_d        = WW'(WINDOW - 1);
    end else if (ctrl_q.guard) begin
      if (win_q == '0) ctrl_d.guard = 1'b0;
      else             win_d        = win_q - 1'b1;
    end
    if (wr_en) begin
      ctrl_d.sel = wr_bits[SEL_W-1:0];
      if (wr_bits[ENA_B])    ctrl_d.ena = 1'b1;
      else if (ctrl_q.guard) ctrl_d.ena = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      win_q  <= win_d;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             kick,
  output logic             expire
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned CW   = BASE_LOG2 + NSEL - 1;

  logic [CW-1:0] term [NSEL];
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          exp_q, exp_d;

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term[g] = (CW'(1) << (BASE_LOG2 + g)) - CW'(1);
  end

  assign lim = term[sel];

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (!run || kick) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire = exp_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 14,
  parameter int unsigned WINDOW      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_rst
);
  logic       rst_core_n;
  wdog_ctrl_t ctrl;
  logic       unused_hi_bits;

  assign unused_hi_bits = ^wr_data[7:5];

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  wdog_ctrl_reg #(.WINDOW(WINDOW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[4:0]),
    .ctrl    (ctrl)
  );

  wdog_timeout #(.BASE_LOG2(BASE_LOG2)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run    (ctrl.ena),
    .sel    (ctrl.sel),
    .tick   (osc_tick),
    .kick   (kick),
    .expire (sys_rst)
  );

  assign rd_data = {3'b000, ctrl};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kick,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sys_rst
);
  p_ena_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> rd_data[3]);

  p_guard_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[4]) |-> $past(wr_en && wr_data[4] && wr_data[3]));

  p_shutoff_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && rd_data[4]) |=> !rd_data[3]);

  p_shutoff_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && !rd_data[4] && !(wr_en && wr_data[4] && wr_data[3])) |=> rd_data[3]);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  p_kick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !sys_rst);

  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |=> !sys_rst);
endmodule

bind wdog_guard wdog_guard_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .kick    (kick),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .sys_rst (sys_rst)
);

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_tick, kick, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sys_rst;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  string req = "R1";

  // reference state
  bit m_guard, m_ena, m_rst;
  int m_win, m_sel, m_cnt;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_LOG2(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sys_rst(sys_rst)
  );

  function automatic int period(input int sel);
    return 1 << (BASE + sel);
  endfunction

  function automatic logic [7:0] exp_rd();
    return {3'b000, m_guard, m_ena, 3'(m_sel)};
  endfunction

  task automatic model_step(input bit we, input logic [7:0] wd, input bit k, input bit t);
    bit old_guard = m_guard;
    bit nr = 0;
    if (!m_ena || k) m_cnt = 0;
    else if (t) begin
      if (m_cnt >= period(m_sel) - 1) begin m_cnt = 0; nr = 1; end
      else m_cnt++;
    end
    if (we && wd[4] && wd[3]) begin m_guard = 1; m_win = 3; end
    else if (m_guard) begin
      if (m_win == 0) m_guard = 0; else m_win--;
    end
    if (we) begin
      m_sel = int'(wd[2:0]);
      if (wd[3]) m_ena = 1;
      else if (old_guard) m_ena = 0;
    end
    m_rst = nr;
  endtask

  task automatic check(input logic [7:0] got_rd, input logic got_rst, input logic [7:0] e_rd, input logic e_rst);
    n_vec++;
    if (got_rd !== e_rd || got_rst !== e_rst) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h sys_rst=%0b expected rd_data=%02h sys_rst=%0b",
               req, got_rd, got_rst, e_rd, e_rst);
    end
  endtask

  task automatic cyc(input bit we, input logic [7:0] wd, input bit k, input bit t);
    wr_en = we; wr_data = wd; kick = k; osc_tick = t;
    @(posedge clk);
    model_step(we, wd, k, t);
    @(negedge clk);
    check(rd_data, sys_rst, exp_rd(), m_rst);
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, t);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_data = 0; kick = 0; osc_tick = 0;
    m_guard = 0; m_ena = 0; m_rst = 0; m_win = 0; m_sel = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    check(rd_data, sys_rst, 8'h00, 1'b0);
    rst_n = 1;
    idle(4, 1);

    req = "R2";  // high bits ignored, select loaded, no enable
    cyc(1, 8'hE5, 0, 0);
    check(rd_data, sys_rst, 8'h05, 1'b0);

    req = "R3";
    cyc(1, 8'h08, 0, 0);
    check(rd_data, sys_rst, 8'h08, 1'b0);

    req = "R6";  // guard-only write without arming does not disable
    cyc(1, 8'h10, 0, 0);
    check(rd_data, sys_rst, 8'h08, 1'b0);
    cyc(1, 8'h00, 0, 0);
    check(rd_data, sys_rst, 8'h08, 1'b0);

    req = "R4";  // guard high for four cycles then self-clears
    cyc(1, 8'h18, 0, 0);
    check(rd_data, sys_rst, 8'h18, 1'b0);
    idle(3, 0);
    check(rd_data, sys_rst, 8'h18, 1'b0);
    idle(1, 0);
    check(rd_data, sys_rst, 8'h08, 1'b0);

    req = "R6";  // shut-off just after window is refused
    cyc(1, 8'h00, 0, 0);
    check(rd_data, sys_rst, 8'h08, 1'b0);

    req = "R5";  // shut-off in the last cycle of window
    cyc(1, 8'h18, 0, 0);
    idle(3, 0);
    cyc(1, 8'h00, 0, 0);
    check(rd_data[3], 1'b0, 1'b0, 1'b0);

    req = "R10";
    idle(200, 1);
    check(rd_data, sys_rst, 8'h10 & rd_data, 1'b0);

    req = "R7";  // shortest period, continuous ticks
    cyc(1, 8'h08, 0, 0);
    idle(15, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd0, 1'b0);
    idle(1, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd1, 1'b0);
    idle(1, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd0, 1'b0);

    req = "R8";  // gaps in ticks
    for (int i = 0; i < 60; i++) cyc(0, 8'h00, 0, (i % 3) == 0);

    req = "R9";  // kick on the final tick
    cyc(1, 8'h08, 1, 0);
    idle(15, 1);
    cyc(0, 8'h00, 1, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd0, 1'b0);
    idle(15, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd0, 1'b0);
    idle(1, 1);
    check({7'd0, sys_rst}, 1'b0, 8'd1, 1'b0);

    req = "R7";  // each length select
    for (int s = 0; s < 8; s++) begin
      cyc(1, 8'h08 | 8'(s), 0, 0);
      idle(period(s) + 2, 1);
    end

    req = "R5";  // random mix
    for (int i = 0; i < 30000; i++) begin
      int r = int'($urandom % 100);
      bit we = 0;
      logic [7:0] wd = 8'h00;
      if (r < 4) begin
        we = 1;
        case ($urandom % 4)
          0: wd = 8'h18 | 8'($urandom % 8) | ($urandom % 2 ? 8'hE0 : 8'h00);
          1: wd = 8'($urandom % 8);
          2: wd = 8'h08 | 8'($urandom % 3);
          default: wd = 8'($urandom);
        endcase
      end
      cyc(we, wd, ($urandom % 100) < 2, ($urandom % 100) < 70);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule